// File: doc/BRIEF.md
# Capture Timer with Edge-Select Control

This block is a free-running up-counter with one input-capture channel and one compare channel. An external capture pin is synchronised. When the edge selected in the control register appears, the counter value of that cycle is copied into a capture register and a sticky detect flag is raised. The flag drives an interrupt request while the interrupt enable is set. Software clears the flag by writing 1 to a dedicated clear bit. It cannot write the flag directly.

Each event has its own mask bit. The first is the capture event. The second is a compare match between the counter and a programmable compare value. When an event's mask bit is 0, that event clears the counter on the next clock. When the mask bit is 1, the counter keeps running through the event. A simple address/data port gives access to the control, compare, capture and counter values. A count-enable input gates counting.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, the control register reads 0x00, the counter reads 0, the capture register reads 0, the compare register reads all ones, and `irq` is low.
- R2: The counter increments by one on every clock while `cnt_en` is 1 and no clearing event applies. It holds its value while `cnt_en` is 0.
- R3: When the counter equals the compare value and control bit 3 is 0, the counter is 0 after the next clock. When bit 3 is 1, the match does not disturb counting.
- R4: `cap_pin` passes through two synchronising flops before edge detection, so an edge driven before clock edge k is acted on at clock edge k+2. Control bits 2:1 select the edge: 00 disables capture, 01 rising, 10 falling, 11 both. Edges that the selection does not cover have no effect.
- R5: On a capture event, the capture register takes the counter value of that same cycle, and the detect flag (control bit 7) becomes 1.
- R6: When control bit 4 is 0, a capture event leaves the counter at 0 after the next clock. When bit 4 is 1, the counter keeps counting through the capture.
- R7: Writing control bit 6 as 1 clears the detect flag, and writing it as 0 leaves the flag unchanged. Bit 6 always reads 0, and the value written to bit 7 is ignored.
- R8: If a clearing write and a capture event fall in the same cycle, the flag ends at 1.
- R9: `irq` is high exactly while control bit 5 and the detect flag are both 1.
- R10: Control bit 0 is stored and read back as written, and its value does not change capture behaviour.
- R11: Address 0 is control (bits 7:0, upper bits read 0), address 1 is compare (read/write), address 2 is capture and address 3 is the counter. Addresses 2 and 3 are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| cap_pin | input | 1 | Asynchronous capture input |
| cnt_en | input | 1 | Count enable |
| irq | output | 1 | Capture interrupt request |

## Verification
Capture is tried with rising, falling and both-edge selection, with the selection off, and with an edge of the wrong polarity. These cases show that the edge decoder honours each code and ignores what it should. One rising edge is probed at two consecutive cycles, which pins the two-flop latency to an exact clock. Captures taken while the counter runs with the clear mask set are kept apart from captures taken while it is stopped with the mask clear. This separates same-cycle latching from the next-cycle clear. A flag-clear write timed onto the capture cycle exercises the set-over-clear priority.

// File: rtl/ect_pkg.sv
`timescale 1ns/1ps
package ect_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Control register image, MSB first (bit 7 down to bit 0).
  typedef struct packed {
    logic       flag;      // 7: capture detected
    logic       clr;       // 6: write-1 clear, reads 0
    logic       irq_en;    // 5
    logic       cap_keep;  // 4: 1 = no clear on capture
    logic       cmp_keep;  // 3: 1 = no clear on compare match
    edge_mode_e mode;      // 2:1
    logic       spare;     // 0: stored, no function
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CAP  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  // Decides whether a sampled transition counts as a capture event.
  function automatic logic edge_hit(input edge_mode_e mode,
                                    input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ect_capture_input.sv
`timescale 1ns/1ps
module ect_capture_input
  import ect_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       cap_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur     = sync_q[SYNC_STAGES-1];
  assign cap_evt = edge_hit(mode, prev_q, cur);

  // R4: a disabled selection never yields an event
  a_r4_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF) |-> !cap_evt);

  // R4: with rising-only selection, an event implies the sampled level rose
  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && mode == EDGE_RISE) |=> prev_q);

endmodule

// File: rtl/ect_counter.sv
`timescale 1ns/1ps
module ect_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cap_evt,
  input  logic             cap_keep,
  input  logic             cmp_keep,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cmp_hit,
  output logic             clr_now
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic en);
    return v + {{(CNT_W-1){1'b0}}, en};
  endfunction

  logic cap_clr;
  logic cmp_clr;

  assign cmp_hit = (cnt_q == cmp_val);
  assign cap_clr = cap_evt & ~cap_keep;
  assign cmp_clr = cmp_hit & ~cmp_keep;
  assign clr_now = cap_clr | cmp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_now) cnt_q <= '0;
    else              cnt_q <= step(cnt_q, cnt_en);
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr_now) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr_now) |=> $stable(cnt_q));

  a_r3_cmp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !cmp_keep) |=> (cnt_q == '0));

  a_r6_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !cap_keep) |=> (cnt_q == '0));

endmodule

// File: rtl/ect_ctrl_regs.sv
`timescale 1ns/1ps
module ect_ctrl_regs
  import ect_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [6:0] wr_bits,
  input  logic       cap_evt,
  output ctrl_t      ctrl_q
);

  logic       flag_q;
  logic       ie_q;
  logic       cap_keep_q;
  logic       cmp_keep_q;
  edge_mode_e mode_q;
  logic       spare_q;
  logic       clr_wr;

  assign clr_wr = wr_ctrl & wr_bits[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      cap_keep_q <= 1'b0;
      cmp_keep_q <= 1'b0;
      mode_q     <= EDGE_OFF;
      spare_q    <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q       <= wr_bits[5];
      cap_keep_q <= wr_bits[4];
      cmp_keep_q <= wr_bits[3];
      mode_q     <= edge_mode_e'(wr_bits[2:1]);
      spare_q    <= wr_bits[0];
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (cap_evt) flag_q <= 1'b1;
    else if (clr_wr)  flag_q <= 1'b0;
  end

  always_comb begin
    ctrl_q          = '0;
    ctrl_q.flag     = flag_q;
    ctrl_q.clr      = 1'b0;
    ctrl_q.irq_en   = ie_q;
    ctrl_q.cap_keep = cap_keep_q;
    ctrl_q.cmp_keep = cmp_keep_q;
    ctrl_q.mode     = mode_q;
    ctrl_q.spare    = spare_q;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_q);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !cap_evt) |=> !flag_q);

  a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && flag_q) |=> flag_q);

endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_pin,
  input  logic             cnt_en,
  output logic             irq
);

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int PAD_W  = CNT_W - CTRL_W;

  ctrl_t            ctrl;
  logic             cap_evt;
  logic             cmp_hit;
  logic             clr_now;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cap_q;
  logic             wr_ctrl;
  logic             wr_cmp;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_cmp  = bus_wr && (bus_addr == ADDR_CMP);

  ect_capture_input #(.SYNC_STAGES(2)) u_cap_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (cap_pin),
    .mode    (ctrl.mode),
    .cap_evt (cap_evt)
  );

  ect_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_bits (bus_wdata[6:0]),
    .cap_evt (cap_evt),
    .ctrl_q  (ctrl)
  );

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cmp_val  (cmp_q),
    .cap_evt  (cap_evt),
    .cap_keep (ctrl.cap_keep),
    .cmp_keep (ctrl.cmp_keep),
    .cnt_q    (cnt_q),
    .cmp_hit  (cmp_hit),
    .clr_now  (clr_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (wr_cmp) cmp_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl};
      ADDR_CMP:  bus_rdata = cmp_q;
      ADDR_CAP:  bus_rdata = cap_q;
      default:   bus_rdata = cnt_q;
    endcase
  end

  assign irq = ctrl.irq_en & ctrl.flag;

  // R5: the capture register holds the counter value of the event cycle
  a_r5_cap_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q)));

  // R5: the capture register only moves on an event
  a_r5_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

  // R9: a new request needs the enable at that moment
  a_r9_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ctrl.irq_en);

  // R3: a masked match never clears the counter on its own
  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ctrl.cmp_keep && !cap_evt && cnt_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: tb/edge_capture_timer_bench.sv
`timescale 1ns/1ps
module edge_capture_timer_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic          bus_wr = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          cap_pin = 1'b0;
  logic          cnt_en = 1'b0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]    addr;
    logic [CW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  edge_capture_timer #(.CNT_W(CW)) u_edge_capture_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_pin   (cap_pin),
    .cnt_en    (cnt_en),
    .irq       (irq)
  );

  // Driver: presents a read address and queues the expected data.
  task automatic rd(input logic [1:0] a, input logic [CW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk);
    cap_pin = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1;
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // Monitor: compares read data against queued items.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=0x%04h expected=0x%04h",
                   it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd1, 16'hFFFF, "R1 compare");
    rd(2'd2, 16'h0000, "R1 capture");
    rd(2'd3, 16'h0000, "R1 counter");
    chk_irq(1'b0, "R1");

    // R3 compare clear: cmp=5, mask 0, 7 enabled clocks -> 1..5,0,1
    wr(2'd1, 16'd5);
    rd(2'd1, 16'd5, "R11 compare rw");
    @(negedge clk); cnt_en = 1'b1;
    wait_cyc(7);
    cnt_en = 1'b0;
    rd(2'd3, 16'd1, "R3 cleared on match");

    // R3 keep: mask 1, cmp=3, 5 clocks from 1 -> 6
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'd3);
    @(negedge clk); cnt_en = 1'b1;
    wait_cyc(5);
    cnt_en = 1'b0;
    rd(2'd3, 16'd6, "R3 masked match keeps counting");
    wait_cyc(3);
    rd(2'd3, 16'd6, "R2 holds while disabled");

    // R11 read-only addresses
    wr(2'd3, 16'h1234);
    rd(2'd3, 16'd6, "R11 counter write ignored");
    wr(2'd2, 16'h4321);
    rd(2'd2, 16'd0, "R11 capture write ignored");

    // R5/R6 rising capture, counter stopped at 6, capture clear active
    wr(2'd0, 16'h000A);
    pin_set(1'b1);
    wait_cyc(2);
    rd(2'd2, 16'd6, "R5 capture value");
    rd(2'd3, 16'd0, "R6 counter cleared on capture");
    rd(2'd0, 16'h008A, "R5 flag set");
    chk_irq(1'b0, "R9 disabled");

    // R9 / R7
    wr(2'd0, 16'h002A);
    chk_irq(1'b1, "R9 enabled with flag");
    rd(2'd0, 16'h00AA, "R7 bit6=0 keeps flag");
    wr(2'd0, 16'h006A);
    rd(2'd0, 16'h002A, "R7 clear and bit6 reads 0");
    chk_irq(1'b0, "R9 flag cleared");

    // R4/R6 falling edge with counting, capture keep: capture 2, counter 3
    wr(2'd0, 16'h001C);
    @(negedge clk); cap_pin = 1'b0; cnt_en = 1'b1;
    wait_cyc(3);
    cnt_en = 1'b0;
    rd(2'd2, 16'd2, "R5 same-cycle latch while counting");
    rd(2'd3, 16'd3, "R6 keep counting through capture");
    rd(2'd0, 16'h009C, "R4 falling edge");
    wr(2'd0, 16'h005C);
    pin_set(1'b1);
    wait_cyc(4);
    rd(2'd0, 16'h001C, "R4 rising ignored in falling mode");
    rd(2'd2, 16'd2, "R4 capture unchanged");

    // R4 both edges
    wr(2'd0, 16'h001E);
    pin_set(1'b0);
    wait_cyc(4);
    rd(2'd0, 16'h009E, "R4 both: falling");
    rd(2'd2, 16'd3, "R4 both: capture value");
    wr(2'd0, 16'h005E);
    pin_set(1'b1);
    wait_cyc(4);
    rd(2'd0, 16'h009E, "R4 both: rising");
    wr(2'd0, 16'h0058);

    // R4 disabled
    pin_set(1'b0);
    wait_cyc(4);
    rd(2'd0, 16'h0018, "R4 off ignores falling");
    pin_set(1'b1);
    wait_cyc(4);
    rd(2'd0, 16'h0018, "R4 off ignores rising");

    // R4 two-flop latency, rising mode
    wr(2'd0, 16'h001A);
    pin_set(1'b0);
    wait_cyc(4);
    rd(2'd0, 16'h001A, "R4 falling ignored in rising mode");
    pin_set(1'b1);
    @(negedge clk);
    rd(2'd0, 16'h001A, "R4 no event after two clocks");
    rd(2'd0, 16'h009A, "R4 event on third clock");

    // R8 clear write lands in the capture cycle
    wr(2'd0, 16'h005A);
    pin_set(1'b0);
    wait_cyc(4);
    pin_set(1'b1);
    @(negedge clk);
    wr(2'd0, 16'h005A);
    rd(2'd0, 16'h009A, "R8 set wins over clear");

    // R10 spare bit
    wr(2'd0, 16'h005B);
    rd(2'd0, 16'h001B, "R10 spare bit readback");
    pin_set(1'b0);
    wait_cyc(4);
    pin_set(1'b1);
    wait_cyc(2);
    rd(2'd0, 16'h009B, "R10 capture unaffected");

    wait_cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule